// File: doc/BRIEF.md
# HDLC Receive Deframer with CRC-16 Check

This block takes a transparent serial line, delivered as octets over a valid/ready handshake, and recovers HDLC frames from it. Each accepted octet is walked one line bit per clock, starting with its most significant bit. A small state machine with two states does the work. `ST_HUNT` looks for an opening flag. `ST_DATA` removes stuffed zeros, assembles bytes, watches for the closing flag or an abort run of ones, and counts received bytes against a limit set at run time.

Every assembled byte goes out on a byte stream. The CRC bytes are included, and the first byte of each frame carries a start marker. When a frame ends, one status pulse gives its outcome as a 2-bit code, together with a byte count. The status pulse is the frame's end marker, and a nonzero code tells the consumer to discard the bytes it already took. A 56 kbit/s adaptation mode uses only the upper seven bits of each octet.

State transitions:
- `ST_HUNT` to `ST_DATA` on a 0, then six 1s, then a 0.
- `ST_DATA` to `ST_DATA` on a flag, which closes one frame and opens the next.
- `ST_DATA` to `ST_HUNT` on a run of seven 1s (abort or idle).
- `ST_DATA` to `ST_HUNT` on an over-length byte.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `out_sof` and `frm_end` are 0.
- R2: An accepted octet is used most significant bit first, one bit per clock. It yields 8 bits, or 7 when `adapt56_en` is 1. `in_ready` is 0 while more than one bit of the octet remains, so after an 8-bit octet is accepted, `in_ready` returns to 1 on the eighth following cycle.
- R3: A 0, six 1s and a 0 form a flag. In `ST_HUNT` a flag opens a frame. Consecutive flags between frames produce neither bytes nor status.
- R4: Inside a frame, a 0 that follows five consecutive 1s is removed and is not a data bit.
- R5: Data bits fill a byte least significant bit first. Each completed byte appears for one cycle on `out_data` with `out_valid`. `out_sof` is set on the first byte after a flag. The two CRC bytes are output like any other byte.
- R6: The CRC is preset to 0xFFFF at each flag and updated per completed byte with the reflected polynomial 0x8408. A closing flag with at least 2 bytes and a CRC of 0xF0B8 gives `frm_end` with code 00 (good) and `frm_len` equal to the byte count minus 2.
- R7: A closing flag with at least 2 bytes and any other CRC value gives code 01 (CRC error), with `frm_len` equal to all bytes received.
- R8: A closing flag after exactly 1 byte gives code 10 (framing error) with `frm_len` equal to 1.
- R9: Seven consecutive 1s inside a frame send the block to `ST_HUNT`. If at least one byte was received, this gives code 10 with `frm_len` equal to the byte count. With no bytes received there is no status.
- R10: A byte that would make the count, CRC bytes included, exceed `max_len` is not output. It gives code 11 (length error) with `frm_len` equal to `max_len`, and the block returns to `ST_HUNT`.
- R11: With `adapt56_en` at 1, bit 0 of every octet is ignored and the upper seven bits are the line bits.
- R12: `frm_end` and `out_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adapt56_en | input | 1 | Use only the upper seven bits of each octet |
| max_len | input | LEN_W | Largest accepted byte count per frame, CRC bytes included (at least 2) |
| in_valid | input | 1 | Octet available |
| in_ready | output | 1 | Octet accepted when high together with `in_valid` |
| in_data | input | 8 | Line octet, sent MSB first |
| out_valid | output | 1 | Recovered byte present |
| out_data | output | 8 | Recovered byte |
| out_sof | output | 1 | First byte of a frame |
| frm_end | output | 1 | One-cycle frame end marker and status |
| frm_code | output | 2 | 00 good, 01 CRC error, 10 framing error, 11 length error |
| frm_len | output | LEN_W | Byte count for the ending frame |

## Verification
A stuck or wrong ones counter shows up at the ports within one frame. If destuffing is wrong, the byte immediately after a run of five ones is shifted. If flag recognition is wrong, the next status pulse is missing or extra. A CRC register that is off turns the next good frame into code 01 at its closing flag. A byte counter fault changes `frm_len`, or makes a length error appear early or late. The scoreboard compares every output byte and every status pulse in order, so a fault is reported on the first beat that differs.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        FS_GOOD    = 2'b00,
        FS_CRC     = 2'b01,
        FS_FRAMING = 2'b10,
        FS_LENGTH  = 2'b11
    } frame_status_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } rx_state_e;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_RV = 16'h8408;
    localparam int          BYTE_W      = 8;
    localparam int          FLAG_ONES   = 6;
    localparam int          STUFF_ONES  = 5;

    // Fold one byte, least significant bit first, into a reflected CRC-16.
    function automatic logic [15:0] crc_fold_byte(input logic [15:0] crc_in,
                                                  input logic [7:0]  data);
        logic [15:0] c;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY_RV;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlc_octet_feeder.sv
module hdlc_octet_feeder #(
    parameter int OCTET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adapt56_en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [OCTET_W-1:0] in_data,
    output logic               bit_valid,
    output logic               bit_value
);
    localparam int CNT_W = $clog2(OCTET_W + 1);

    logic [OCTET_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;
    logic               take;

    assign in_ready  = (left_q <= CNT_W'(1));
    assign take      = in_valid && in_ready;
    assign bit_valid = (left_q != '0);
    assign bit_value = sh_q[OCTET_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (take) begin
            sh_q   <= in_data;
            left_q <= adapt56_en ? CNT_W'(OCTET_W - 1) : CNT_W'(OCTET_W);
        end else if (left_q != '0) begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - CNT_W'(1);
        end
    end

    // R2: an accepted octet yields a line bit on the very next cycle
    assert_accept_starts_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> bit_valid);

    // R2: the remaining-bit count never exceeds one octet
    assert_left_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CNT_W'(OCTET_W));

endmodule

// File: rtl/hdlc_rx_fsm.sv
module hdlc_rx_fsm
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_value,
    input  logic [LEN_W-1:0] max_len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             frm_end,
    output logic [1:0]       frm_code,
    output logic [LEN_W-1:0] frm_len
);
    rx_state_e        state_q, state_n;
    logic [2:0]       ones_q, ones_n, ones_inc;
    logic [7:0]       acc_q, acc_n;
    logic [2:0]       bcnt_q, bcnt_n;
    logic [LEN_W-1:0] nbytes_q, nbytes_n;
    logic [15:0]      crc_q, crc_n;
    logic             sofp_q, sofp_n;

    logic             ov_n, os_n, fe_n;
    logic [7:0]       od_n;
    logic [1:0]       fc_n;
    logic [LEN_W-1:0] fl_n;
    logic             shift_in;

    assign ones_inc = (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;

    always_comb begin
        state_n  = state_q;
        ones_n   = ones_q;
        acc_n    = acc_q;
        bcnt_n   = bcnt_q;
        nbytes_n = nbytes_q;
        crc_n    = crc_q;
        sofp_n   = sofp_q;
        ov_n     = 1'b0;
        od_n     = out_data;
        os_n     = 1'b0;
        fe_n     = 1'b0;
        fc_n     = frm_code;
        fl_n     = frm_len;
        shift_in = 1'b0;

        if (bit_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (bit_value) begin
                        ones_n = ones_inc;
                    end else begin
                        if (ones_q == 3'(FLAG_ONES)) begin
                            state_n  = ST_DATA;
                            crc_n    = CRC_PRESET;
                            nbytes_n = '0;
                            bcnt_n   = '0;
                            sofp_n   = 1'b1;
                        end
                        ones_n = '0;
                    end
                end
                ST_DATA: begin
                    if (bit_value) begin
                        ones_n = ones_inc;
                        if (ones_inc == 3'd7) begin
                            if (nbytes_q != '0) begin
                                fe_n = 1'b1;
                                fc_n = FS_FRAMING;
                                fl_n = nbytes_q;
                            end
                            state_n = ST_HUNT;
                        end else if (ones_inc <= 3'(STUFF_ONES)) begin
                            shift_in = 1'b1;
                        end
                    end else begin
                        ones_n = '0;
                        if (ones_q == 3'(FLAG_ONES)) begin
                            if (nbytes_q != '0) begin
                                fe_n = 1'b1;
                                if (nbytes_q < LEN_W'(2)) begin
                                    fc_n = FS_FRAMING;
                                    fl_n = nbytes_q;
                                end else if (crc_q != CRC_RESIDUE) begin
                                    fc_n = FS_CRC;
                                    fl_n = nbytes_q;
                                end else begin
                                    fc_n = FS_GOOD;
                                    fl_n = nbytes_q - LEN_W'(2);
                                end
                            end
                            crc_n    = CRC_PRESET;
                            nbytes_n = '0;
                            bcnt_n   = '0;
                            sofp_n   = 1'b1;
                        end else if (ones_q != 3'(STUFF_ONES)) begin
                            shift_in = 1'b1;
                        end
                    end

                    if (shift_in) begin
                        acc_n = {bit_value, acc_q[7:1]};
                        if (bcnt_q == 3'd7) begin
                            bcnt_n = '0;
                            if (nbytes_q >= max_len) begin
                                fe_n    = 1'b1;
                                fc_n    = FS_LENGTH;
                                fl_n    = nbytes_q;
                                state_n = ST_HUNT;
                                ones_n  = '0;
                            end else begin
                                crc_n    = crc_fold_byte(crc_q, acc_n);
                                nbytes_n = nbytes_q + LEN_W'(1);
                                ov_n     = 1'b1;
                                od_n     = acc_n;
                                os_n     = sofp_q;
                                sofp_n   = 1'b0;
                            end
                        end else begin
                            bcnt_n = bcnt_q + 3'd1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            ones_q   <= '0;
            acc_q    <= '0;
            bcnt_q   <= '0;
            nbytes_q <= '0;
            crc_q    <= CRC_PRESET;
            sofp_q   <= 1'b0;
        end else begin
            state_q  <= state_n;
            ones_q   <= ones_n;
            acc_q    <= acc_n;
            bcnt_q   <= bcnt_n;
            nbytes_q <= nbytes_n;
            crc_q    <= crc_n;
            sofp_q   <= sofp_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            frm_end   <= 1'b0;
            frm_code  <= FS_GOOD;
            frm_len   <= '0;
        end else begin
            out_valid <= ov_n;
            out_data  <= od_n;
            out_sof   <= os_n;
            frm_end   <= fe_n;
            frm_code  <= fc_n;
            frm_len   <= fl_n;
        end
    end

    // R12: a status pulse never shares a cycle with a data byte
    assert_no_byte_with_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && frm_end));

    // R5: the start marker only rides on a data beat
    assert_sof_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R10: no reported length goes beyond the configured limit
    assert_len_within_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |-> (frm_len <= max_len));

    // R9: a seven-ones run leaves the frame for hunting on the next cycle
    assert_abort_to_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && bit_valid && bit_value && ones_q == 3'd6) |=> (state_q == ST_HUNT));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adapt56_en,
    input  logic [LEN_W-1:0] max_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             frm_end,
    output logic [1:0]       frm_code,
    output logic [LEN_W-1:0] frm_len
);
    logic line_valid;
    logic line_bit;

    hdlc_octet_feeder #(.OCTET_W(BYTE_W)) u_feeder (
        .clk        (clk),
        .rst_n      (rst_n),
        .adapt56_en (adapt56_en),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .bit_valid  (line_valid),
        .bit_value  (line_bit)
    );

    hdlc_rx_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (line_valid),
        .bit_value (line_bit),
        .max_len   (max_len),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .frm_end   (frm_end),
        .frm_code  (frm_code),
        .frm_len   (frm_len)
    );

endmodule

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             adapt56_en = 1'b0;
    logic [LEN_W-1:0] max_len = LEN_W'(64);
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = 8'h00;
    logic             out_valid;
    logic [7:0]       out_data;
    logic             out_sof;
    logic             frm_end;
    logic [1:0]       frm_code;
    logic [LEN_W-1:0] frm_len;

    always #5 clk = ~clk;

    hdlc_rx_deframer #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .adapt56_en(adapt56_en), .max_len(max_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .frm_end(frm_end), .frm_code(frm_code), .frm_len(frm_len)
    );

    typedef struct {
        logic             is_end;
        logic [7:0]       data;
        logic             sof;
        logic [1:0]       code;
        logic [LEN_W-1:0] len;
        string            req;
    } exp_t;

    exp_t exp_q[$];
    bit   line_q[$];
    int   stuff_ones = 0;
    bit   filler = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (out_valid || frm_end)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R9", "unexpected output beat", {out_valid, frm_end}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_end) begin
                    check(frm_end && !out_valid, e.req, "end marker", {out_valid, frm_end}, 1);
                    check(frm_code == e.code, e.req, "status code", frm_code, e.code);
                    check(frm_len == e.len, e.req, "frame length", frm_len, e.len);
                end else begin
                    check(out_valid && !frm_end, e.req, "byte beat", {out_valid, frm_end}, 2);
                    check(out_data == e.data, e.req, "byte value", out_data, e.data);
                    check(out_sof == e.sof, e.req, "start marker", out_sof, e.sof);
                end
            end
        end
    end

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic exp_byte(input logic [7:0] d, input bit sof, input string req);
        exp_t e;
        e.is_end = 1'b0; e.data = d; e.sof = sof; e.code = 2'b00; e.len = '0; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic exp_end(input logic [1:0] code, input int len, input string req);
        exp_t e;
        e.is_end = 1'b1; e.data = 8'h00; e.sof = 1'b0; e.code = code; e.len = LEN_W'(len); e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic put_flag();
        line_q.push_back(1'b0);
        for (int i = 0; i < 6; i++) line_q.push_back(1'b1);
        line_q.push_back(1'b0);
        stuff_ones = 0;
    endtask

    task automatic put_ones(input int n);
        for (int i = 0; i < n; i++) line_q.push_back(1'b1);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            line_q.push_back(b[i]);
            if (b[i]) begin
                stuff_ones++;
                if (stuff_ones == 5) begin
                    line_q.push_back(1'b0);
                    stuff_ones = 0;
                end
            end else begin
                stuff_ones = 0;
            end
        end
    endtask

    task automatic push_octet(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Pack queued line bits into octets, MSB first; pad with ones
    task automatic flush_line();
        while (line_q.size() != 0) begin
            logic [7:0] o;
            for (int k = 7; k >= 0; k--) begin
                if (adapt56_en && k == 0) begin
                    o[k] = filler;
                    filler = ~filler;
                end else if (line_q.size() != 0) begin
                    o[k] = line_q.pop_front();
                end else begin
                    o[k] = 1'b1;
                end
            end
            push_octet(o);
        end
        repeat (24) @(negedge clk);
    endtask

    // Frame body: bytes plus CRC, optional corrupted CRC, then closing flag
    task automatic put_frame(input logic [7:0] pl[$], input bit bad_crc, input string req);
        logic [15:0] c;
        logic [7:0]  lo, hi;
        c = 16'hFFFF;
        foreach (pl[i]) begin
            c = crc_step(c, pl[i]);
            put_byte(pl[i]);
            exp_byte(pl[i], i == 0, req);
        end
        c  = ~c;
        lo = c[7:0] ^ (bad_crc ? 8'h01 : 8'h00);
        hi = c[15:8];
        put_byte(lo); exp_byte(lo, pl.size() == 0, req);
        put_byte(hi); exp_byte(hi, 1'b0, req);
        put_flag();
        if (bad_crc) exp_end(2'b01, pl.size() + 2, req);
        else         exp_end(2'b00, pl.size(), req);
    endtask

    task automatic drain(input string req);
        int w;
        w = 0;
        while (exp_q.size() != 0 && w < 2000) begin
            @(negedge clk);
            w++;
        end
        check(exp_q.size() == 0, req, "missing expected beats", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pl[$];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(frm_end == 1'b0, "R1", "frm_end after reset", frm_end, 0);

        // R2: ready timing for an 8-bit octet (all ones, harmless in hunt)
        in_valid = 1'b1; in_data = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2", "ready one cycle after accept", in_ready, 0);
        repeat (6) @(negedge clk);
        check(in_ready == 1'b0, "R2", "ready with two bits left", in_ready, 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R2", "ready on last bit", in_ready, 1);
        repeat (4) @(negedge clk);

        // R3 R4 R5 R6: good frame, stuffing-heavy payload, back-to-back opening flags
        put_flag(); put_flag(); put_flag();
        pl = '{8'hFF, 8'h7E, 8'h3F, 8'h01};
        put_frame(pl, 1'b0, "R4/R6");
        put_ones(10);
        flush_line();
        drain("R6");

        // R3 R5: two frames sharing one flag
        put_flag();
        pl = '{8'hA5};
        put_frame(pl, 1'b0, "R3");
        pl = '{8'h00, 8'hC3};
        put_frame(pl, 1'b0, "R5");
        put_flag();
        put_ones(10);
        flush_line();
        drain("R3");

        // R7: CRC error
        put_flag();
        pl = '{8'h12, 8'h34};
        put_frame(pl, 1'b1, "R7");
        put_ones(10);
        flush_line();
        drain("R7");

        // R8: closing flag after a single byte
        put_flag();
        put_byte(8'h55); exp_byte(8'h55, 1'b1, "R8");
        put_flag(); exp_end(2'b10, 1, "R8");
        put_ones(10);
        flush_line();
        drain("R8");

        // R9: abort after two bytes, then an empty aborted opening (silent)
        put_flag();
        put_byte(8'h11); exp_byte(8'h11, 1'b1, "R9");
        put_byte(8'h22); exp_byte(8'h22, 1'b0, "R9");
        line_q.push_back(1'b0);
        put_ones(9); exp_end(2'b10, 2, "R9");
        put_flag();
        put_ones(12);
        flush_line();
        drain("R9");

        // R10: length limit of 4 bytes, 5-byte payload
        max_len = LEN_W'(4);
        put_flag();
        pl = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        foreach (pl[i]) begin
            put_byte(pl[i]);
            if (i < 4) exp_byte(pl[i], i == 0, "R10");
        end
        exp_end(2'b11, 4, "R10");
        put_byte(8'h9A); put_byte(8'hBC);
        put_flag();
        put_ones(10);
        flush_line();
        drain("R10");
        max_len = LEN_W'(64);

        // R11: adaptation mode, bit 0 of each octet alternates and is ignored
        adapt56_en = 1'b1;
        put_flag(); put_flag();
        pl = '{8'h81, 8'h7F, 8'hE0};
        put_frame(pl, 1'b0, "R11");
        put_ones(10);
        flush_line();
        drain("R11");
        adapt56_en = 1'b0;

        // R12 R1: idle line afterwards stays silent
        put_ones(40);
        flush_line();
        check(exp_q.size() == 0 && !out_valid && !frm_end, "R12", "quiet idle line",
              {out_valid, frm_end}, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule